// File: doc/BRIEF.md
# Receive Destination-Address Filter

This block decides, for each received Ethernet frame, whether it should be kept. It watches the first six bytes of the frame, which are the destination address, as they stream past on an 8-bit bus with a valid strobe and a start-of-frame flag. It returns a keep or drop verdict one cycle after the sixth address byte.

Unicast addresses are compared against a programmed station address. For multicast addresses the block runs a CRC-32 over the six address bytes. The top six bits of that CRC select one bit of a 64-bit hash table, and that bit decides the frame. Control bits can switch the filter to one of several looser policies: keep everything, keep all multicast, or apply the hash table to multicast. Broadcast frames are kept by default, and a separate bit can block them.

Configuration is written through a small word-wide register port. Everything after the address (payload, frame check sequence, tags, framing) is handled elsewhere.

Top module: `rxDestFilter`

## Requirements
- R1: In hash mode (mode bit 2), a multicast frame is kept exactly when hash-table bit `idx` is 1. `idx` is CRC bits 31..26. The CRC uses the reflected polynomial 0xEDB88320 and starts at 0xFFFFFFFF. It takes the address bytes first byte first and each byte least-significant bit first. No final inversion is applied.
- R2: The table is two 32-bit words: bits 31..0 at register 3 and bits 63..32 at register 4. `idx[5]` selects the word and `idx[4:0]` selects the bit within it.
- R3: With mode bit 0 (keep-all) set, every frame is kept.
- R4: With mode bit 1 (all-multicast) set, every multicast frame is kept whatever the table holds. A frame is multicast when bit 0 of its first address byte is 1.
- R5: With no mode bit set, non-broadcast multicast frames are dropped. A unicast frame is kept only on an exact match with the station address. Station address byte `k` (k = 0 is the first byte received) sits at register 1 bits 8k+7..8k for k < 4, and at register 2 bits 8(k-4)+7..8(k-4) for k = 4, 5.
- R6: The all-ones address is kept unless mode bit 3 (block-broadcast) is set. When that bit is set, it is dropped unless keep-all is on.
- R7: `verdictValid` rises in the cycle after the sixth valid address byte. It and `verdictAccept` then hold until the next start-of-frame. Idle cycles between bytes are allowed, and bytes after the sixth have no effect.
- R8: A byte with `inSof` set starts a new address: `verdictValid` is 0 in the next cycle and counting restarts from that byte, including when the previous frame stopped part-way through its address.
- R9: The verdict uses the register values present in the cycle of the sixth byte. Register 0 bits 3..0 are the mode bits.
- R10: After reset, `verdictValid` and `verdictAccept` are 0 and all registers are 0. `verdictAccept` is never 1 while `verdictValid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| regWe | input | 1 | Register write enable |
| regAddr | input | 3 | Register index (0 mode, 1-2 station, 3-4 hash) |
| regWdata | input | 32 | Register write data |
| inValid | input | 1 | Receive byte valid |
| inSof | input | 1 | Marks the first byte of a frame |
| inByte | input | 8 | Receive byte |
| verdictValid | output | 1 | Verdict available for the current frame |
| verdictAccept | output | 1 | 1 keep the frame, 0 drop it |

## Verification
The bench tries a unicast address that matches the station address and one that differs only in its last byte. This separates a full compare from a partial one. It sends group addresses whose hash bit is programmed in the correct word, in the opposite word, and as the only bit left clear. These tell a right index apart from a swapped word or an ignored table. Broadcast is sent under every combination of block-broadcast and keep-all, which exposes the priority between the modes. Further runs with idle gaps, trailing bytes and an aborted address show whether counting and holding follow the frame markers rather than raw cycles.

// File: rtl/rxDestFilterPkg.sv
package rxDestFilterPkg;
  localparam int BYTE_W      = 8;
  localparam int ADDR_BYTES  = 6;
  localparam int ADDR_W      = BYTE_W * ADDR_BYTES;
  localparam int HASH_BITS   = 64;
  localparam int HASH_WORD_W = 32;
  localparam int HASH_WORDS  = HASH_BITS / HASH_WORD_W;
  localparam int IDX_W       = $clog2(HASH_BITS);
  localparam int CRC_W       = 32;
  localparam int CNT_W       = $clog2(ADDR_BYTES + 1);
  localparam int REG_AW      = 3;
  localparam int REG_DW      = 32;
  localparam logic [CRC_W-1:0] CRC_POLY = 32'hEDB8_8320;
  localparam logic [CRC_W-1:0] CRC_INIT = 32'hFFFF_FFFF;

  localparam int REG_MODE    = 0;
  localparam int REG_STA_LO  = 1;
  localparam int REG_STA_HI  = 2;
  localparam int REG_HASH_LO = 3;

  // promisc ends up at bit 0 of the packed struct
  typedef struct packed {
    logic bcastBlock;
    logic hashPerfect;
    logic passMulti;
    logic promisc;
  } modeBits_t;

  typedef struct packed {
    modeBits_t             mode;
    logic [ADDR_W-1:0]     station;
    logic [HASH_BITS-1:0]  hashTable;
  } filtCfg_t;

  typedef struct packed {
    logic             startFrame;
    logic             takeByte;
    logic             finalByte;
    logic [CNT_W-1:0] slot;
  } byteStrobe_t;

  function automatic logic [CRC_W-1:0] crcByte(input logic [CRC_W-1:0] c,
                                               input logic [BYTE_W-1:0] d);
    logic [CRC_W-1:0] r;
    r = c;
    for (int b = 0; b < BYTE_W; b++)
      r = (r >> 1) ^ ((r[0] ^ d[b]) ? CRC_POLY : '0);
    return r;
  endfunction
endpackage

// File: rtl/rxDestFilterRegs.sv
module rxDestFilterRegs
  import rxDestFilterPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              regWe,
  input  logic [REG_AW-1:0] regAddr,
  input  logic [REG_DW-1:0] regWdata,
  output filtCfg_t          cfg
);
  modeBits_t            modeQ;
  logic [ADDR_W-1:0]    stationQ;
  logic [HASH_BITS-1:0] hashFlat;

  always_ff @(posedge clk) begin
    if (rst) begin
      modeQ    <= '0;
      stationQ <= '0;
    end else if (regWe) begin
      if (regAddr == REG_AW'(REG_MODE))
        modeQ <= modeBits_t'(regWdata[3:0]);
      if (regAddr == REG_AW'(REG_STA_LO))
        stationQ[REG_DW-1:0] <= regWdata;
      if (regAddr == REG_AW'(REG_STA_HI))
        stationQ[ADDR_W-1:REG_DW] <= regWdata[ADDR_W-REG_DW-1:0];
    end
  end

  for (genvar w = 0; w < HASH_WORDS; w++) begin : g_hash
    logic [HASH_WORD_W-1:0] wordQ;
    always_ff @(posedge clk) begin
      if (rst)
        wordQ <= '0;
      else if (regWe && regAddr == REG_AW'(REG_HASH_LO + w))
        wordQ <= regWdata[HASH_WORD_W-1:0];
    end
    assign hashFlat[w*HASH_WORD_W +: HASH_WORD_W] = wordQ;
  end

  assign cfg = '{mode: modeQ, station: stationQ, hashTable: hashFlat};
endmodule

// File: rtl/rxDestFilterCtrl.sv
module rxDestFilterCtrl
  import rxDestFilterPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        inValid,
  input  logic        inSof,
  output byteStrobe_t strb
);
  logic [CNT_W-1:0] cntQ;   // bytes captured; ADDR_BYTES means idle

  always_comb begin
    strb = '0;
    if (inValid) begin
      if (inSof) begin
        strb.startFrame = 1'b1;
        strb.takeByte   = 1'b1;
        strb.slot       = '0;
        strb.finalByte  = (ADDR_BYTES == 1);
      end else if (cntQ < CNT_W'(ADDR_BYTES)) begin
        strb.takeByte  = 1'b1;
        strb.slot      = cntQ;
        strb.finalByte = (cntQ == CNT_W'(ADDR_BYTES - 1));
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      cntQ <= CNT_W'(ADDR_BYTES);
    else if (strb.takeByte)
      cntQ <= strb.slot + CNT_W'(1);
  end
endmodule

// File: rtl/rxDestFilterDp.sv
module rxDestFilterDp
  import rxDestFilterPkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  byteStrobe_t       strb,
  input  logic [BYTE_W-1:0] inByte,
  input  filtCfg_t          cfg,
  output logic              verdictValid,
  output logic              verdictAccept
);
  logic [CRC_W-1:0]  crcQ, crcBase, crcNext;
  logic [ADDR_W-1:0] fullAddr;
  logic [IDX_W-1:0]  hashIdx;
  logic hashHit, isMulti, isBcast, stationHit, acceptNow;

  assign crcBase = strb.startFrame ? CRC_INIT : crcQ;
  assign crcNext = crcByte(crcBase, inByte);

  always_ff @(posedge clk) begin
    if (rst)
      crcQ <= CRC_INIT;
    else if (strb.takeByte)
      crcQ <= crcNext;
  end

  // the last address byte is used straight from the bus, never stored
  for (genvar k = 0; k < ADDR_BYTES; k++) begin : g_addr
    if (k < ADDR_BYTES - 1) begin : g_store
      logic [BYTE_W-1:0] byteQ;
      always_ff @(posedge clk) begin
        if (rst)
          byteQ <= '0;
        else if (strb.takeByte && strb.slot == CNT_W'(k))
          byteQ <= inByte;
      end
      assign fullAddr[k*BYTE_W +: BYTE_W] = byteQ;
    end else begin : g_live
      assign fullAddr[k*BYTE_W +: BYTE_W] = inByte;
    end
  end

  assign hashIdx    = crcNext[CRC_W-1 -: IDX_W];
  assign hashHit    = cfg.hashTable[hashIdx];
  assign isMulti    = fullAddr[0];
  assign isBcast    = &fullAddr;
  assign stationHit = (fullAddr == cfg.station);

  always_comb begin
    if (cfg.mode.promisc)
      acceptNow = 1'b1;
    else if (isBcast)
      acceptNow = !cfg.mode.bcastBlock;
    else if (isMulti)
      acceptNow = cfg.mode.passMulti || (cfg.mode.hashPerfect && hashHit);
    else
      acceptNow = stationHit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      verdictValid  <= 1'b0;
      verdictAccept <= 1'b0;
    end else if (strb.finalByte) begin
      verdictValid  <= 1'b1;
      verdictAccept <= acceptNow;
    end else if (strb.startFrame) begin
      verdictValid  <= 1'b0;
      verdictAccept <= 1'b0;
    end
  end
endmodule

// File: rtl/rxDestFilter.sv
module rxDestFilter
  import rxDestFilterPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        regWe,
  input  logic [2:0]  regAddr,
  input  logic [31:0] regWdata,
  input  logic        inValid,
  input  logic        inSof,
  input  logic [7:0]  inByte,
  output logic        verdictValid,
  output logic        verdictAccept
);
  filtCfg_t    cfg;
  byteStrobe_t strb;

  rxDestFilterRegs u_regs (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr),
    .regWdata(regWdata), .cfg(cfg)
  );

  rxDestFilterCtrl u_ctrl (
    .clk(clk), .rst(rst), .inValid(inValid), .inSof(inSof), .strb(strb)
  );

  rxDestFilterDp u_dp (
    .clk(clk), .rst(rst), .strb(strb), .inByte(inByte), .cfg(cfg),
    .verdictValid(verdictValid), .verdictAccept(verdictAccept)
  );
endmodule

// File: rtl/rxDestFilterChk.sv
module rxDestFilterChk (
  input logic clk,
  input logic rst,
  input logic inValid,
  input logic inSof,
  input logic promiscOn,
  input logic verdictValid,
  input logic verdictAccept
);
  // R7: once given, the verdict stays until a new frame starts
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    verdictValid && !(inValid && inSof) |=> verdictValid && $stable(verdictAccept));

  // R7: a verdict only appears right after a non-start address byte
  a_r7_rise_on_byte: assert property (@(posedge clk) disable iff (rst)
    $rose(verdictValid) |-> $past(inValid && !inSof));

  // R8: a start-of-frame withdraws the previous verdict
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    inValid && inSof |=> !verdictValid);

  // R3: keep-all mode always yields a keep verdict
  a_r3_promisc: assert property (@(posedge clk) disable iff (rst)
    $rose(verdictValid) && $past(promiscOn) |-> verdictAccept);

  // R10: no keep indication without a verdict
  a_r10_qualified: assert property (@(posedge clk) disable iff (rst)
    !verdictValid |-> !verdictAccept);
endmodule

bind rxDestFilter rxDestFilterChk u_chk (
  .clk(clk), .rst(rst), .inValid(inValid), .inSof(inSof),
  .promiscOn(cfg.mode.promisc),
  .verdictValid(verdictValid), .verdictAccept(verdictAccept)
);

// File: tb/test_rxDestFilter.sv
module test_rxDestFilter;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG   = 100000;

  logic clk = 1'b0, rst = 1'b1;
  logic regWe = 1'b0;
  logic [2:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic inValid = 1'b0, inSof = 1'b0;
  logic [7:0] inByte = '0;
  logic verdictValid, verdictAccept;

  int compared = 0, mismatched = 0, cycles = 0;
  string curReq = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  rxDestFilter i_rxDestFilter (
    .clk(clk), .rst(rst), .regWe(regWe), .regAddr(regAddr), .regWdata(regWdata),
    .inValid(inValid), .inSof(inSof), .inByte(inByte),
    .verdictValid(verdictValid), .verdictAccept(verdictAccept)
  );

  // ---------------- reference model ----------------
  int          mCnt = 6;
  logic [47:0] mAddr = '0;
  logic [3:0]  mMode = '0;
  logic [47:0] mSta = '0;
  logic [63:0] mHash = '0;
  logic        mValid = 1'b0, mAcc = 1'b0, started = 1'b0;

  function automatic logic [31:0] refCrc(input logic [47:0] a);
    logic [31:0] c = 32'hFFFF_FFFF;
    for (int i = 0; i < 48; i++) begin
      logic fb = c[0] ^ a[i];
      c = c >> 1;
      if (fb) c = c ^ 32'hEDB8_8320;
    end
    return c;
  endfunction

  function automatic logic refDecide(input logic [47:0] a);
    int idx = int'(refCrc(a) >> 26);
    if (mMode[0]) return 1'b1;
    if (a == 48'hFFFF_FFFF_FFFF) return !mMode[3];
    if (a[0]) return mMode[1] || (mMode[2] && mHash[idx]);
    return a == mSta;
  endfunction

  always @(posedge clk) begin
    started = 1'b1;
    if (rst) begin
      mCnt = 6; mValid = 0; mAcc = 0; mMode = 0; mSta = 0; mHash = 0;
    end else begin
      if (inValid) begin
        if (inSof) begin
          mAddr[7:0] = inByte; mCnt = 1; mValid = 0; mAcc = 0;
        end else if (mCnt < 6) begin
          mAddr[8*mCnt +: 8] = inByte;
          mCnt++;
          if (mCnt == 6) begin mValid = 1; mAcc = refDecide(mAddr); end
        end
      end
      if (regWe) begin
        case (regAddr)
          3'd0: mMode = regWdata[3:0];
          3'd1: mSta[31:0] = regWdata;
          3'd2: mSta[47:32] = regWdata[15:0];
          3'd3: mHash[31:0] = regWdata;
          3'd4: mHash[63:32] = regWdata;
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (started) begin
      compared++;
      if (verdictValid !== mValid || verdictAccept !== mAcc) begin
        mismatched++;
        $display("FAIL %s: valid/accept actual %b/%b expected %b/%b at %0t",
                 curReq, verdictValid, verdictAccept, mValid, mAcc, $time);
      end
    end
  end

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      mismatched++;
      $display("FAIL watchdog: actual %0d cycles expected <= %0d", cycles, WATCHDOG);
      finishRun();
    end
  end

  // ---------------- stimulus ----------------
  function automatic logic [47:0] mk(input logic [7:0] b0, b1, b2, b3, b4, b5);
    return {b5, b4, b3, b2, b1, b0};
  endfunction

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    regWe = 1'b1; regAddr = 3'(a); regWdata = d;
    @(negedge clk);
    regWe = 1'b0;
  endtask

  task automatic sendAddr(input logic [47:0] a, input int gap, input int extra,
                          input int stopAt);
    for (int i = 0; i < 6 && i < stopAt; i++) begin
      @(negedge clk);
      inValid = 1'b1; inSof = (i == 0); inByte = a[8*i +: 8];
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        inValid = 1'b0;
      end
    end
    for (int e = 0; e < extra; e++) begin
      @(negedge clk);
      inValid = 1'b1; inSof = 1'b0; inByte = 8'(8'hA5 + e);
    end
    @(negedge clk);
    inValid = 1'b0; inSof = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic sendHashProg(input logic [47:0] a, input int variant);
    int idx = int'(refCrc(a) >> 26);
    logic [63:0] t = 64'd1 << idx;
    if (variant == 1) t = ~t;               // only the wanted bit cleared
    if (variant == 2) t = {t[31:0], t[63:32]}; // bit placed in the wrong word
    wr(3, t[31:0]);
    wr(4, t[63:32]);
    sendAddr(a, 0, 0, 6);
  endtask

  initial begin
    logic [47:0] sta = mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55);
    logic [47:0] bc  = 48'hFFFF_FFFF_FFFF;
    logic [47:0] mc  = mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'h09);
    curReq = "R10";
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    curReq = "R5";
    wr(1, sta[31:0]); wr(2, {16'h0, sta[47:32]});
    sendAddr(sta, 0, 0, 6);
    sendAddr(mk(8'h02, 8'h11, 8'h22, 8'h33, 8'h44, 8'h56), 0, 0, 6);
    sendAddr(mk(8'h03, 8'h11, 8'h22, 8'h33, 8'h44, 8'h55), 0, 0, 6);
    sendAddr(mc, 0, 0, 6);

    curReq = "R6";
    sendAddr(bc, 0, 0, 6);
    wr(0, 32'h8);
    sendAddr(bc, 0, 0, 6);
    wr(0, 32'h9);
    sendAddr(bc, 0, 0, 6);

    curReq = "R3";
    sendAddr(mk(8'h40, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05), 0, 0, 6);
    sendAddr(mc, 1, 0, 6);

    curReq = "R4";
    wr(0, 32'h2);
    sendAddr(mc, 0, 0, 6);
    sendAddr(mk(8'h33, 8'h33, 8'h00, 8'h00, 8'h00, 8'h01), 0, 0, 6);
    sendAddr(mk(8'h40, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05), 0, 0, 6);

    wr(0, 32'h4);
    for (int k = 0; k < 8; k++) begin
      logic [47:0] a = mk(8'h01, 8'h00, 8'h5E, 8'h00, 8'h00, 8'(k * 37));
      curReq = "R1"; sendHashProg(a, 0);
      curReq = "R1"; sendHashProg(a, 1);
      curReq = "R2"; sendHashProg(a, 2);
    end
    curReq = "R1";
    sendAddr(sta, 0, 0, 6);
    wr(3, 32'hFFFF_FFFF); wr(4, 32'hFFFF_FFFF);
    sendAddr(mk(8'h40, 8'h01, 8'h02, 8'h03, 8'h04, 8'h05), 0, 0, 6);

    curReq = "R7";
    wr(0, 32'h0);
    sendAddr(sta, 3, 4, 6);
    sendAddr(sta, 0, 0, 6);
    repeat (5) @(negedge clk);

    curReq = "R8";
    sendAddr(mk(8'h01, 8'h02, 8'h03, 8'h04, 8'h05, 8'h06), 0, 0, 3);
    sendAddr(sta, 0, 0, 6);
    sendAddr(mc, 0, 0, 2);
    sendAddr(sta, 2, 0, 6);

    curReq = "R9";
    @(negedge clk);
    inValid = 1'b1; inSof = 1'b1; inByte = sta[7:0];
    for (int i = 1; i < 6; i++) begin
      @(negedge clk);
      inSof = 1'b0; inByte = sta[8*i +: 8];
      if (i == 5) begin regWe = 1'b1; regAddr = 3'd1; regWdata = 32'h0; end
    end
    @(negedge clk);
    inValid = 1'b0; regWe = 1'b0;
    repeat (3) @(negedge clk);
    sendAddr(sta, 0, 0, 6);

    curReq = "R10";
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    sendAddr(sta, 0, 0, 6);
    sendAddr(mc, 0, 0, 6);

    finishRun();
  end
endmodule